// File: doc/BRIEF.md
# Two-Phase Duty Profile Sequencer

This block drives the compare input of an external up-counting PWM generator through a fixed two-step duty profile. A start pulse opens a full-on step. The sequencer produces this step by writing a compare value one above the PWM period, which the counter can never reach. After a set number of coarse ticks it writes half of the period count and holds that for a longer run of ticks. It then falls back to idle with a compare value of zero, which gives 0% duty, and raises a done flag.

The coarse tick comes from a prescaler on the system clock. It is unrelated to the PWM period, so the duration of each step does not depend on the PWM frequency. With the default settings one tick is 100 ms at 125 MHz, the full-on step is 6 ticks (0.6 s) and the half step is 70 ticks (7 s). The tick divider is a parameter, so a bench can shorten the time base.

Top module: `duty_profile_seq`

## Requirements
- R1: After reset, `phaseOut` is 0 (idle), `compareOut` is 0, and `busy` and `done` are both low.
- R2: A high `start` sampled at a clock edge while idle makes the next cycle show `phaseOut` = 1 (full-on), `busy` = 1, `done` = 0 and `compareOut` = `periodVal` + 1, a value strictly above the period.
- R3: The full-on step lasts exactly FULL_TICKS × TICK_DIV clock cycles. It is always followed by step `phaseOut` = 2 (half duty) and never by any other step.
- R4: The half step shows `compareOut` = floor((`periodVal` + 1) / 2), never above the period, and lasts exactly HALF_TICKS × TICK_DIV clock cycles.
- R5: When the half step ends, `phaseOut` returns to 0, `compareOut` becomes 0 and `done` goes high. `done` stays high until a start is accepted.
- R6: A `start` pulse while `busy` is high has no effect on the step, the compare value or the step timing.
- R7: `compareOut` changes only at step boundaries. A change of `periodVal` during a step has no effect until the next boundary samples it.
- R8: With `periodVal` at its all-ones maximum, the full-on compare value is 2^CMP_W and does not wrap to zero.
- R9: `busy` is high exactly when `phaseOut` is non-zero, and `busy` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts the profile when idle |
| periodVal | input | CMP_W | PWM period count of the external generator |
| compareOut | output | CMP_W+1 | Compare value to the PWM generator |
| phaseOut | output | 2 | 0 idle, 1 full-on, 2 half duty |
| busy | output | 1 | Profile in progress |
| done | output | 1 | Profile finished, held until the next start |

## Verification
Every result is registered once. The step, compare value, busy and done all reflect a start or a tick boundary in the cycle that follows the sampling edge. The step lengths are therefore whole multiples of the tick divider, counted from the start edge. The bench keeps a behavioural model that counts down the remaining cycles of each step with integers. The model updates on the same rising edge as the design, and all four outputs are compared on the following falling edge of every cycle. Explicit checks count the cycles spent in each step, capture the compare value on the first cycle of each step, and look at the outputs on the falling edge right after a start sent while busy or a mid-step period change.

// File: rtl/duty_profile_pkg.sv
package duty_profile_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_FULL = 2'd1,
    PH_HALF = 2'd2
  } phase_t;

  typedef struct packed {
    logic clearTimers;
    logic runTimers;
    logic loadFull;
    logic loadHalf;
    logic loadZero;
  } seq_strobe_t;

endpackage

// File: rtl/duty_profile_dp.sv
module duty_profile_dp
  import duty_profile_pkg::*;
#(
  parameter int TICK_DIV   = 12_500_000,
  parameter int FULL_TICKS = 6,
  parameter int HALF_TICKS = 70,
  parameter int CMP_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_strobe_t      strobe,
  input  logic [CMP_W-1:0] periodVal,
  output logic             fullDone,
  output logic             halfDone,
  output logic [CMP_W:0]   compareOut
);

  localparam int MAX_TICKS = (FULL_TICKS > HALF_TICKS) ? FULL_TICKS : HALF_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(FULL_TICKS - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_TICKS - 1);

  logic             tick;
  logic [CNT_W-1:0] tickCnt;
  logic [CMP_W:0]   compareReg;
  logic [CMP_W:0]   fullVal;
  logic [CMP_W:0]   halfVal;

  // Coarse time base: one tick every TICK_DIV clocks while running
  generate
    if (TICK_DIV == 1) begin : g_noPresc
      assign tick = strobe.runTimers;
    end else begin : g_presc
      localparam int PRE_W = $clog2(TICK_DIV + 1);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
      logic [PRE_W-1:0] prescCnt;

      always_ff @(posedge clk) begin
        if (!rstN || strobe.clearTimers || !strobe.runTimers) begin
          prescCnt <= '0;
        end else if (prescCnt == PRE_LAST) begin
          prescCnt <= '0;
        end else begin
          prescCnt <= prescCnt + 1'b1;
        end
      end

      assign tick = strobe.runTimers && (prescCnt == PRE_LAST);

      AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
        prescCnt <= PRE_LAST); // R3
    end
  endgenerate

  // Ticks elapsed inside the current step
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearTimers || strobe.loadHalf || strobe.loadZero) begin
      tickCnt <= '0;
    end else if (tick) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  assign fullDone = tick && (tickCnt == FULL_LAST);
  assign halfDone = tick && (tickCnt == HALF_LAST);

  // Compare values: one above the period forces the output fully on
  assign fullVal = {1'b0, periodVal} + (CMP_W + 1)'(1);
  assign halfVal = fullVal >> 1;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.loadZero) begin
      compareReg <= '0;
    end else if (strobe.loadFull) begin
      compareReg <= fullVal;
    end else if (strobe.loadHalf) begin
      compareReg <= halfVal;
    end
  end

  assign compareOut = compareReg;

  AST_FULL_ABOVE_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFull |=> compareOut > {1'b0, $past(periodVal)}); // R2

  AST_HALF_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadHalf |=> compareOut <= {1'b0, $past(periodVal)}); // R4

  AST_COMPARE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadFull || strobe.loadHalf || strobe.loadZero) |=> $stable(compareOut)); // R7

endmodule

// File: rtl/duty_profile_ctrl.sv
module duty_profile_ctrl
  import duty_profile_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        fullDone,
  input  logic        halfDone,
  output seq_strobe_t strobe,
  output phase_t      phase,
  output logic        busy,
  output logic        done
);

  phase_t phaseQ, phaseD;
  logic   doneQ, doneD;

  always_comb begin
    phaseD = phaseQ;
    doneD  = doneQ;
    strobe = '0;
    strobe.runTimers = (phaseQ != PH_IDLE);
    unique case (phaseQ)
      PH_IDLE: begin
        if (start) begin
          phaseD             = PH_FULL;
          doneD              = 1'b0;
          strobe.loadFull    = 1'b1;
          strobe.clearTimers = 1'b1;
        end
      end
      PH_FULL: begin
        if (fullDone) begin
          phaseD          = PH_HALF;
          strobe.loadHalf = 1'b1;
        end
      end
      PH_HALF: begin
        if (halfDone) begin
          phaseD          = PH_IDLE;
          doneD           = 1'b1;
          strobe.loadZero = 1'b1;
        end
      end
      default: begin
        phaseD          = PH_IDLE;
        strobe.loadZero = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      doneQ  <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      doneQ  <= doneD;
    end
  end

  assign phase = phaseQ;
  assign busy  = (phaseQ != PH_IDLE);
  assign done  = doneQ;

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !fullDone && !halfDone) |=> (phaseQ == $past(phaseQ))); // R6

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !(doneQ && busy)); // R9

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !start) |=> doneQ); // R5

  AST_HALF_AFTER_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_FULL) |=> (phaseQ == PH_FULL || phaseQ == PH_HALF)); // R3

endmodule

// File: rtl/duty_profile_seq.sv
module duty_profile_seq
  import duty_profile_pkg::*;
#(
  parameter int TICK_DIV   = 12_500_000,
  parameter int FULL_TICKS = 6,
  parameter int HALF_TICKS = 70,
  parameter int CMP_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CMP_W-1:0] periodVal,
  output logic [CMP_W:0]   compareOut,
  output logic [1:0]       phaseOut,
  output logic             busy,
  output logic             done
);

  seq_strobe_t strobe;
  phase_t      phase;
  logic        fullDone;
  logic        halfDone;

  duty_profile_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .fullDone (fullDone),
    .halfDone (halfDone),
    .strobe   (strobe),
    .phase    (phase),
    .busy     (busy),
    .done     (done)
  );

  duty_profile_dp #(
    .TICK_DIV   (TICK_DIV),
    .FULL_TICKS (FULL_TICKS),
    .HALF_TICKS (HALF_TICKS),
    .CMP_W      (CMP_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .periodVal  (periodVal),
    .fullDone   (fullDone),
    .halfDone   (halfDone),
    .compareOut (compareOut)
  );

  assign phaseOut = phase;

endmodule

// File: tb/test_duty_profile_seq.sv
`timescale 1ns/1ps
module test_duty_profile_seq;

  localparam int DIV   = 3;
  localparam int FULLT = 6;
  localparam int HALFT = 70;
  localparam int W     = 8;
  localparam int FULL_CYC = FULLT * DIV;
  localparam int HALF_CYC = HALFT * DIV;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] periodVal = '0;
  logic [W:0]   compareOut;
  logic [1:0]   phaseOut;
  logic         busy;
  logic         done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  duty_profile_seq #(
    .TICK_DIV (DIV), .FULL_TICKS (FULLT), .HALF_TICKS (HALFT), .CMP_W (W)
  ) i_duty_profile_seq (
    .clk (clk), .rstN (rstN), .start (start), .periodVal (periodVal),
    .compareOut (compareOut), .phaseOut (phaseOut), .busy (busy), .done (done)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: step number, cycles left, compare value, done flag
  int mPhase = 0;
  int mLeft  = 0;
  int mCmp   = 0;
  bit mDone  = 0;
  bit modelOn = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mPhase <= 0; mLeft <= 0; mCmp <= 0; mDone <= 0;
    end else begin
      case (mPhase)
        0: if (start) begin
             mPhase <= 1; mLeft <= FULL_CYC; mCmp <= int'(periodVal) + 1; mDone <= 0;
           end
        1: if (mLeft == 1) begin
             mPhase <= 2; mLeft <= HALF_CYC; mCmp <= (int'(periodVal) + 1) / 2;
           end else mLeft <= mLeft - 1;
        default: if (mLeft == 1) begin
             mPhase <= 0; mLeft <= 0; mCmp <= 0; mDone <= 1;
           end else mLeft <= mLeft - 1;
      endcase
    end
    modelOn <= 1'b1;
  end

  // Cycle-by-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (modelOn) begin
      chk(int'(phaseOut) == mPhase, "R3", "model phase", int'(phaseOut), mPhase);
      chk(int'(compareOut) == mCmp,
          (mPhase == 1) ? "R2" : (mPhase == 2) ? "R4" : "R5",
          "model compare", int'(compareOut), mCmp);
      chk(done == mDone, "R5", "model done", int'(done), int'(mDone));
      chk(busy == (mPhase != 0), "R9", "model busy", int'(busy), int'(mPhase != 0));
      chk(!(busy && done), "R9", "busy with done", int'(busy && done), 0);
    end
  end

  // Watchdog
  always @(negedge clk) begin
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Runs one profile; counts cycles per step and captures each step's compare
  task automatic runProfile(input logic [W-1:0] per, input int expHalf);
    int fullCnt = 0;
    int halfCnt = 0;
    int halfCmp = -1;
    periodVal = per;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(phaseOut == 2'd1, "R2", "step after start", int'(phaseOut), 1);
    chk(int'(compareOut) == int'(per) + 1, "R2", "full compare", int'(compareOut), int'(per) + 1);
    chk(busy && !done, "R2", "busy/done after start", int'({busy, done}), 2);
    for (int i = 0; i < 1000 && phaseOut != 2'd0; i++) begin
      if (phaseOut == 2'd1) fullCnt++;
      if (phaseOut == 2'd2) begin
        if (halfCmp < 0) halfCmp = int'(compareOut);
        halfCnt++;
      end
      @(negedge clk);
    end
    chk(fullCnt == FULL_CYC, "R3", "full step length", fullCnt, FULL_CYC);
    chk(halfCnt == HALF_CYC, "R4", "half step length", halfCnt, HALF_CYC);
    chk(halfCmp == expHalf, "R4", "half compare", halfCmp, expHalf);
    chk(done == 1'b1, "R5", "done at end", int'(done), 1);
    chk(compareOut == '0, "R5", "zero compare at end", int'(compareOut), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(phaseOut == 2'd0 && !busy && !done, "R1", "reset state",
        int'({phaseOut, busy, done}), 0);
    chk(compareOut == '0, "R1", "reset compare", int'(compareOut), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Plain profile with period 100
    runProfile(8'd100, 50);

    // done held while idle
    repeat (10) @(negedge clk);
    chk(done == 1'b1 && phaseOut == 2'd0, "R5", "done held idle",
        int'({done, phaseOut}), 4);

    // Start while busy and period change mid step
    periodVal = 8'd60;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R2", "done cleared on start", int'(done), 0);
    repeat (4) @(negedge clk);
    start = 1'b1;
    periodVal = 8'd40;
    @(negedge clk);
    start = 1'b0;
    chk(phaseOut == 2'd1, "R6", "step after busy start", int'(phaseOut), 1);
    chk(int'(compareOut) == 61, "R7", "compare held after period change", int'(compareOut), 61);
    repeat (3) @(negedge clk);
    chk(int'(compareOut) == 61, "R6", "compare after busy start", int'(compareOut), 61);
    while (phaseOut != 2'd2) @(negedge clk);
    chk(int'(compareOut) == 20, "R7", "half compare samples new period", int'(compareOut), 20);
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(phaseOut == 2'd2 && int'(compareOut) == 20, "R6", "half step after busy start",
        int'(compareOut), 20);
    while (phaseOut != 2'd0) @(negedge clk);
    chk(done == 1'b1, "R5", "done after disturbed run", int'(done), 1);

    // Maximum period: no wrap of the full-on value
    runProfile(8'hFF, 128);
    chk(1'b1, "R8", "max period run completed", 0, 0);

    // Zero period and odd period
    runProfile(8'd0, 0);
    runProfile(8'd7, 4);

    // Start held high through the end of the profile: restart right after done
    periodVal = 8'd10;
    start = 1'b1;
    @(negedge clk);
    while (phaseOut != 2'd0) @(negedge clk);
    chk(done == 1'b1, "R5", "done with start held", int'(done), 1);
    @(negedge clk);
    start = 1'b0;
    chk(phaseOut == 2'd1 && !done, "R2", "restart with start held", int'(phaseOut), 1);
    while (phaseOut != 2'd0) @(negedge clk);

    // Reset mid-profile returns to the reset state
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(phaseOut == 2'd0 && compareOut == '0 && !busy && !done, "R1", "reset mid run",
        int'(compareOut), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule